// File: doc/BRIEF.md
# Two-Wire Serial ADC Readout Controller

This block runs on the host side of a serial converter link that has no chip select. Only two wires are left: a serial clock that the block drives and a data line that the converter drives. The block waits for a conversion to finish and then clocks the 16-bit result in, most significant bit first. It finishes by giving the clock edge that starts the next conversion. The word appears on a parallel output together with a one-cycle valid strobe, and then the cycle repeats without any further control.

A static mode input sets the idle level of the serial clock, and the protocol depends on it. With an idle-high clock, the converter holds the data line high while it converts and pulls it low once a result is waiting. The block polls for that low level, issues sixteen data pulses and then a seventeenth pulse that starts a new conversion. With an idle-low clock, the data line carries no ready flag. The block instead waits a fixed number of system clocks, reads the first bit before any clock edge, and issues exactly sixteen pulses. The falling edge of the last pulse starts the next conversion.

The serial clock comes from the system clock through a divider that sets the length of each half period. The data input goes through a two-flop synchronizer before any use. After reset the block assumes that a conversion is already in progress.

Top module: `adc2w_reader`

## Requirements
- R1: While reset is asserted, `sck_out` sits at the idle level of the selected mode (1 when `mode_idle_hi` is 1, 0 otherwise), `rd_valid` is 0 and `rd_word` is 0.
- R2: With `mode_idle_hi` = 1, `sck_out` stays high between reads, and no falling edge is issued while the converter keeps the data line high (conversion in progress). A read starts only after the synchronized data line has been seen low.
- R3: With `mode_idle_hi` = 1, each read consists of exactly 17 clock pulses (fall then rise). The 17th pulse carries no data and starts the next conversion.
- R4: With `mode_idle_hi` = 0, `sck_out` stays low between reads. The first rising edge of a read comes no sooner than `CONV_WAIT` system clocks after the falling edge that started the conversion, or after reset is released.
- R5: With `mode_idle_hi` = 0, each read consists of exactly 16 pulses (rise then fall), and the 16th falling edge starts the next conversion.
- R6: Bits are assembled most significant first, and `rd_word` equals the word the converter shifted out. In idle-low mode bit 15 is taken before the first rising edge. In idle-high mode each bit is taken at a rising edge.
- R7: `rd_valid` is high for exactly one system clock per read, and `rd_word` changes only in a cycle in which `rd_valid` is high.
- R8: During a read, every high and every low phase of `sck_out` lasts exactly `HALF_DIV` system clocks.
- R9: Once a read has begun it always runs to its last pulse without a pause, whatever the data line does in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_idle_hi | input | 1 | Static clock polarity select: 1 = idle-high with ready polling, 0 = idle-low with timed wait |
| sdo_in | input | 1 | Serial data from the converter (asynchronous) |
| sck_out | output | 1 | Serial clock to the converter |
| rd_word | output | DATA_W | Last result read |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_word` |

## Verification
The hardest case to reach from the ports is an idle-high read whose last bit is zero. In that case the data line stays low through the whole 17th pulse and rises only when the converter starts its next conversion. If the block polled too early, it would mistake that stale low for a new ready flag. The bench converter model drives every bit from the clock edges it observes and raises the line only on the trigger edge. The data set includes words that end in zero, all ones and all zeros. Any clock edge issued while the model is still converting is reported at once.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_XFER = 1'b1
  } rd_state_t;

endpackage

// File: rtl/adc2w_sync.sv
module adc2w_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/adc2w_tick.sv
module adc2w_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc2w_timer.sv
module adc2w_timer #(
  parameter int CONV_WAIT = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);

  localparam int MW = $clog2(CONV_WAIT + 1);
  localparam logic [MW-1:0] LIMIT = MW'(CONV_WAIT);

  logic [MW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = (cnt_q == LIMIT);
    cnt_en = clr | ~done;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc2w_seq.sv
module adc2w_seq
  import adc2w_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_hi,
  input  logic              sdo_s,
  input  logic              tmr_done,
  output logic              sck,
  output logic              tmr_clr,
  output logic              xfer,
  output logic [CNT_W-1:0]  pulse_cnt,
  output logic [DATA_W-1:0] word,
  output logic              word_vld
);

  localparam logic [CNT_W-1:0] N_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_LAST = CNT_W'(DATA_W - 1);

  rd_state_t         st_q, st_d;
  logic              ph_q, ph_d;
  logic [CNT_W-1:0]  pc_q, pc_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q, vld_d;

  logic ready, edge_go, rise, fall, end_hi, end_lo, take_bit;
  logic [DATA_W-1:0] sh_next;

  // ph_q is the active phase; sck relative to idle level
  assign sck = ph_q ^ mode_hi;

  always_comb begin
    ready    = mode_hi ? ~sdo_s : tmr_done;
    edge_go  = tick & ((st_q == ST_XFER) | ready);
    rise     = edge_go & ~sck;
    fall     = edge_go & sck;
    end_hi   = mode_hi & rise & (pc_q == N_DATA);
    end_lo   = ~mode_hi & fall & (pc_q == N_DATA);
    take_bit = rise & (pc_q < N_DATA);
    sh_next  = {sh_q[DATA_W-2:0], sdo_s};

    st_d  = st_q;
    ph_d  = ph_q;
    pc_d  = pc_q;
    sh_d  = sh_q;
    res_d = res_q;
    vld_d = 1'b0;

    if (edge_go) begin
      ph_d = ~ph_q;
      st_d = ST_XFER;
    end
    if (rise) pc_d = pc_q + 1'b1;
    if (take_bit) begin
      sh_d = sh_next;
      if (pc_q == N_LAST) begin
        res_d = sh_next;
        vld_d = 1'b1;
      end
    end
    if (end_hi | end_lo) begin
      st_d = ST_WAIT;
      pc_d = '0;
    end
  end

  assign tmr_clr   = end_lo;
  assign xfer      = (st_q == ST_XFER);
  assign pulse_cnt = pc_q;
  assign word      = res_q;
  assign word_vld  = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      ph_q  <= 1'b0;
      pc_q  <= '0;
      sh_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      pc_q  <= pc_d;
      sh_q  <= sh_d;
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/adc2w_reader.sv
module adc2w_reader #(
  parameter int DATA_W    = 16,
  parameter int HALF_DIV  = 4,
  parameter int CONV_WAIT = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_idle_hi,
  input  logic              sdo_in,
  output logic              sck_out,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_valid
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  logic             rst_sync_n;
  logic             sdo_s;
  logic             tick;
  logic             tmr_clr;
  logic             tmr_done;
  logic             xfer;
  logic [CNT_W-1:0] pulse_cnt;

  adc2w_sync #(.RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_sync_n)
  );

  // idle data level is high so a reset never reads as ready
  adc2w_sync #(.RST_VAL(1'b1)) u_sdo_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (sdo_in),
    .q    (sdo_s)
  );

  adc2w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (tick)
  );

  adc2w_timer #(.CONV_WAIT(CONV_WAIT)) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (tmr_clr),
    .done (tmr_done)
  );

  adc2w_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .mode_hi  (mode_idle_hi),
    .sdo_s    (sdo_s),
    .tmr_done (tmr_done),
    .sck      (sck_out),
    .tmr_clr  (tmr_clr),
    .xfer     (xfer),
    .pulse_cnt(pulse_cnt),
    .word     (rd_word),
    .word_vld (rd_valid)
  );

endmodule

// File: rtl/adc2w_reader_chk.sv
module adc2w_reader_chk #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_hi,
  input logic              sck_out,
  input logic [DATA_W-1:0] rd_word,
  input logic              rd_valid,
  input logic              sdo_s,
  input logic              tick,
  input logic              xfer,
  input logic              tmr_done,
  input logic [CNT_W-1:0]  pulse_cnt
);

  p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_word));

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> (sck_out == mode_hi));

  p_poll_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && $rose(xfer)) |-> !$past(sdo_s));

  p_timed_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && $rose(xfer)) |-> $past(tmr_done));

  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(DATA_W));

  p_sck_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_out) |-> $past(tick));

endmodule

bind adc2w_reader adc2w_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_hi  (mode_idle_hi),
  .sck_out  (sck_out),
  .rd_word  (rd_word),
  .rd_valid (rd_valid),
  .sdo_s    (sdo_s),
  .tick     (tick),
  .xfer     (xfer),
  .tmr_done (tmr_done),
  .pulse_cnt(pulse_cnt)
);

// File: tb/adc2w_reader_tb.sv
`timescale 1ns/1ps
module adc2w_reader_tb;

  localparam int HD  = 4;
  localparam int CW  = 120;
  localparam int CT  = 100;
  localparam int NRD = 6;

  logic        clk;
  logic        rst_n;
  logic        mode_hi;
  logic        sdo_in;
  logic        sck_out;
  logic [15:0] rd_word;
  logic        rd_valid;

  int total = 0;
  int bad   = 0;

  adc2w_reader #(.DATA_W(16), .HALF_DIV(HD), .CONV_WAIT(CW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_idle_hi(mode_hi),
    .sdo_in      (sdo_in),
    .sck_out     (sck_out),
    .rd_word     (rd_word),
    .rd_valid    (rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: pick = 16'h0000;
      1: pick = 16'hFFFF;
      2: pick = 16'hA5C2;
      3: pick = 16'h8001;
      4: pick = 16'h7FFE;
      default: pick = 16'($urandom);
    endcase
  endfunction

  // behavioural converter model and per-clock reference checks
  logic [15:0] cur_w;
  logic [15:0] prev_res;
  bit          busy, in_x, prev_sck;
  int          conv_left, nr, nf, phase_len, since_trig, vld_n, reads;

  task automatic end_conv();
    chk(mode_hi ? (nr == 17) : (nr == 16), mode_hi ? "R3" : "R5", nr, mode_hi ? 17 : 16);
    chk(vld_n == 1, "R7", vld_n, 1);
    reads++;
    in_x       = 1'b0;
    busy       = 1'b1;
    conv_left  = CT;
    since_trig = 0;
    cur_w      = pick(reads);
    sdo_in     = 1'b1;
  endtask

  initial begin
    sdo_in = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        busy = 1'b1; conv_left = CT; in_x = 1'b0; nr = 0; nf = 0;
        phase_len = 0; since_trig = 0; vld_n = 0; reads = 0;
        cur_w = pick(0); sdo_in = 1'b1; prev_sck = sck_out; prev_res = rd_word;
      end else begin
        since_trig++;
        phase_len++;
        if (busy) begin
          conv_left--;
          if (conv_left == 0) begin
            busy   = 1'b0;
            sdo_in = mode_hi ? 1'b0 : cur_w[15];
          end
        end
        if (sck_out != prev_sck) begin
          if (in_x) chk(phase_len == HD, "R8", phase_len, HD);
          phase_len = 0;
          if (!in_x) begin
            in_x = 1'b1; nr = 0; nf = 0; vld_n = 0;
            if (!mode_hi) chk(since_trig >= CW, "R4", since_trig, CW);
          end
          if (!sck_out) begin
            nf++;
            if (mode_hi) begin
              chk(!busy, "R2", busy, 0);
              if (nf <= 16) sdo_in = cur_w[16-nf];
            end else begin
              if (nf < 16) sdo_in = cur_w[15-nf];
              if (nf == 16) end_conv();
            end
          end else begin
            nr++;
            if (!mode_hi) chk(!busy, "R4", busy, 0);
            if (mode_hi && nr == 17) end_conv();
          end
        end else if (!in_x) begin
          chk(sck_out == mode_hi, mode_hi ? "R2" : "R4", sck_out, mode_hi);
        end else if (phase_len > HD) begin
          chk(1'b0, "R9", phase_len, HD);
        end
        if (rd_valid) begin
          vld_n++;
          chk(in_x && rd_word == cur_w, "R6", rd_word, cur_w);
        end else begin
          chk(rd_word == prev_res, "R7", rd_word, prev_res);
        end
        prev_res = rd_word;
        prev_sck = sck_out;
      end
    end
  end

  task automatic run_mode(input bit m);
    bit done;
    rst_n   = 1'b0;
    mode_hi = m;
    repeat (4) @(negedge clk);
    chk(sck_out == m, "R1", sck_out, m);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    chk(rd_word == 16'h0, "R1", rd_word, 0);
    rst_n = 1'b1;
    done  = 1'b0;
    for (int c = 0; c < 40000 && !done; c++) begin
      @(negedge clk);
      if (reads >= NRD) done = 1'b1;
    end
    chk(done, "WATCHDOG", reads, NRD);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n   = 1'b0;
    mode_hi = 1'b1;
    run_mode(1'b1);
    run_mode(1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule